// File: doc/BRIEF.md
# Multi-String LED Burst Dimming Regulator

This block closes an average-current loop around each of several parallel LED strings. Every string has its own series switch, and this block drives it with a low-rate burst PWM gate. Over one dimming period, the block adds up the current samples taken while a string's gate is on. It takes the period average and subtracts it from a shared target. It scales the error by a shared proportional gain and centres the result at half of the carrier peak. The clamped result becomes that string's duty for the next period.

A single triangular carrier serves all strings. A string's gate is high whenever its duty exceeds the carrier. The up/down carrier spans exactly one dimming period, and duties change only at its minimum. The carrier length is a parameter. In a deployment it is sized so that the period is 2.5 ms (400 Hz); the default here keeps the period short. Each string can be disabled on its own, which drops its gate and parks its duty at half scale.

Top module: `led_burst_dimmer`

## Requirements
- R1: On reset, every duty is set to half scale (PEAK/2, with PEAK = 2^CAR_W) and every accumulator is cleared. An enabled string is therefore on for exactly PEAK cycles of its first period.
- R2: The carrier level counts 0,1,…,PEAK-1, then PEAK-1,…,1,0, so one period is 2·PEAK clocks and starts on the first clock after reset. In any clock, an enabled string's gate equals (duty > carrier level).
- R3: In each clock the accumulator adds the string's 10-bit unsigned sample only while that string's gate is high. Samples presented while the gate is low have no effect on the next duty.
- R4: In the last clock of a period, the new duty is computed as follows. The period average is A = floor(acc/(2·PEAK)), where acc includes that clock's sample. The new duty is PEAK/2 + floor((ref − A)·gain/16), where gain is 8-bit unsigned with 4 fraction bits. ref and gain are read in that same clock. The new duty governs the gate from the next clock onward, and the duty stays constant at all other times.
- R5: Duty is clamped to the range 0…PEAK. Duty PEAK keeps the gate high for the whole period, and duty 0 keeps it low for the whole period.
- R6: A string whose enable is low has its gate low in that same clock and adds nothing to its accumulator. If the enable is low in the last clock of a period, the string's duty becomes half scale.
- R7: The strings run independent loops that share ref and gain. Strings given identical samples from identical starting duties produce identical gates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_i | input | 10 | Target average current, in sample units |
| gain_i | input | 8 | Proportional gain, unsigned, 4 fraction bits |
| str_en_i | input | 5 | Per-string enable |
| samp_i | input | 50 | Current samples, string k at bits [10k+9:10k] |
| gate_o | output | 5 | Per-string series-switch gate |

## Verification
Each gate is a combinational function of the registered duty, the registered carrier and the live enable. A change in enable therefore shows at the gate in the same clock. A sample or a ref/gain value applied in a period's last clock shows up as a changed gate pattern from the very next clock. The bench drives every input on the falling edge and compares all five gates one nanosecond later. It then advances a behavioural model of the carrier, accumulators and duty law, and the design commits the same step at the following rising edge, so expected and actual values always refer to the same clock.

// File: rtl/led_dim_pkg.sv
package led_dim_pkg;

    localparam int DEF_STRINGS   = 5;
    localparam int DEF_SAMP_W    = 10;
    localparam int DEF_GAIN_W    = 8;
    localparam int DEF_GAIN_FRAC = 4;
    localparam int DEF_CAR_W     = 4;

    typedef enum logic {
        SLOPE_UP   = 1'b0,
        SLOPE_DOWN = 1'b1
    } slope_e;

    // Proportional law centred at half scale, clamped to [0, peak].
    function automatic int duty_law(input int avg, input int target,
                                    input int gain, input int frac,
                                    input int half, input int peak);
        int err;
        int scaled;
        int d;
        err    = target - avg;
        scaled = (err * gain) >>> frac;
        d      = half + scaled;
        if (d < 0)
            d = 0;
        else if (d > peak)
            d = peak;
        return d;
    endfunction

endpackage

// File: rtl/led_dim_carrier.sv
module led_dim_carrier
    import led_dim_pkg::*;
#(
    parameter int CAR_W = DEF_CAR_W
) (
    input  logic             clk,
    input  logic             rst,
    output logic [CAR_W-1:0] level_o,
    output logic             wrap_o
);
    localparam int PH_W = CAR_W + 1;

    logic [PH_W-1:0] phase_q;
    slope_e          slope;

    always_ff @(posedge clk) begin
        if (rst)
            phase_q <= '0;
        else
            phase_q <= phase_q + PH_W'(1);
    end

    always_comb begin
        slope   = phase_q[CAR_W] ? SLOPE_DOWN : SLOPE_UP;
        level_o = (slope == SLOPE_DOWN) ? ~phase_q[CAR_W-1:0] : phase_q[CAR_W-1:0];
        wrap_o  = &phase_q;
    end

endmodule

// File: rtl/led_dim_string.sv
module led_dim_string
    import led_dim_pkg::*;
#(
    parameter int SAMP_W    = DEF_SAMP_W,
    parameter int GAIN_W    = DEF_GAIN_W,
    parameter int GAIN_FRAC = DEF_GAIN_FRAC,
    parameter int CAR_W     = DEF_CAR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en_i,
    input  logic [SAMP_W-1:0] samp_i,
    input  logic [SAMP_W-1:0] ref_i,
    input  logic [GAIN_W-1:0] gain_i,
    input  logic [CAR_W-1:0]  level_i,
    input  logic              wrap_i,
    output logic              gate_o,
    output logic [CAR_W:0]    duty_o
);
    localparam int PEAK   = 1 << CAR_W;
    localparam int HALF   = PEAK / 2;
    localparam int DUTY_W = CAR_W + 1;
    localparam int ACC_W  = SAMP_W + CAR_W + 1;

    logic [DUTY_W-1:0] duty_q;
    logic [ACC_W-1:0]  acc_q;
    logic [ACC_W-1:0]  acc_sum;
    logic [SAMP_W-1:0] avg;
    logic              gate;
    int                law;

    always_comb begin
        gate    = en_i && (duty_q > {1'b0, level_i});
        acc_sum = acc_q + (gate ? ACC_W'(samp_i) : ACC_W'(0));
        // Division by the 2*PEAK period length is a slice of the top bits.
        avg     = acc_sum[ACC_W-1 -: SAMP_W];
        law     = duty_law(int'(avg), int'(ref_i), int'(gain_i),
                           GAIN_FRAC, HALF, PEAK);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            duty_q <= DUTY_W'(HALF);
            acc_q  <= '0;
        end else if (wrap_i) begin
            duty_q <= en_i ? DUTY_W'(law) : DUTY_W'(HALF);
            acc_q  <= '0;
        end else begin
            acc_q  <= en_i ? acc_sum : '0;
        end
    end

    assign gate_o = gate;
    assign duty_o = duty_q;

endmodule

// File: rtl/led_burst_dimmer.sv
module led_burst_dimmer
    import led_dim_pkg::*;
#(
    parameter int N_STR     = DEF_STRINGS,
    parameter int SAMP_W    = DEF_SAMP_W,
    parameter int GAIN_W    = DEF_GAIN_W,
    parameter int GAIN_FRAC = DEF_GAIN_FRAC,
    parameter int CAR_W     = DEF_CAR_W
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [SAMP_W-1:0]        ref_i,
    input  logic [GAIN_W-1:0]        gain_i,
    input  logic [N_STR-1:0]         str_en_i,
    input  logic [N_STR*SAMP_W-1:0]  samp_i,
    output logic [N_STR-1:0]         gate_o
);
    localparam int DUTY_W = CAR_W + 1;

    logic [CAR_W-1:0]        car_level;
    logic                    car_wrap;
    logic [N_STR*DUTY_W-1:0] duty_all;

    led_dim_carrier #(.CAR_W(CAR_W)) u_carrier (
        .clk     (clk),
        .rst     (rst),
        .level_o (car_level),
        .wrap_o  (car_wrap)
    );

    for (genvar g = 0; g < N_STR; g++) begin : g_str
        led_dim_string #(
            .SAMP_W    (SAMP_W),
            .GAIN_W    (GAIN_W),
            .GAIN_FRAC (GAIN_FRAC),
            .CAR_W     (CAR_W)
        ) u_loop (
            .clk     (clk),
            .rst     (rst),
            .en_i    (str_en_i[g]),
            .samp_i  (samp_i[g*SAMP_W +: SAMP_W]),
            .ref_i   (ref_i),
            .gain_i  (gain_i),
            .level_i (car_level),
            .wrap_i  (car_wrap),
            .gate_o  (gate_o[g]),
            .duty_o  (duty_all[g*DUTY_W +: DUTY_W])
        );
    end

endmodule

// File: rtl/led_dim_checker.sv
module led_dim_checker #(
    parameter int N     = 5,
    parameter int CAR_W = 4
) (
    input logic                   clk,
    input logic                   rst,
    input logic [N-1:0]           en,
    input logic [N-1:0]           gate,
    input logic [CAR_W-1:0]       level,
    input logic                   wrap,
    input logic [N*(CAR_W+1)-1:0] duty_all
);
    localparam int DW = CAR_W + 1;
    localparam logic [DW-1:0] PEAK_V = DW'(1 << CAR_W);
    localparam logic [DW-1:0] HALF_V = DW'((1 << CAR_W) / 2);

    assert_reset_half_R1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (duty_all == {N{HALF_V}}));

    assert_carrier_restart_R2: assert property (@(posedge clk) disable iff (rst)
        wrap |=> (level == CAR_W'(0)));

    assert_carrier_step_R2: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((level == $past(level)) ||
                  (level == $past(level) + CAR_W'(1)) ||
                  (level + CAR_W'(1) == $past(level))));

    for (genvar i = 0; i < N; i++) begin : g_chk
        assert_duty_range_R5: assert property (@(posedge clk) disable iff (rst)
            duty_all[i*DW +: DW] <= PEAK_V);

        assert_duty_hold_R4: assert property (@(posedge clk) disable iff (rst)
            !wrap |=> $stable(duty_all[i*DW +: DW]));

        assert_disabled_half_R6: assert property (@(posedge clk) disable iff (rst)
            (wrap && !en[i]) |=> (duty_all[i*DW +: DW] == HALF_V));

        assert_gate_quiet_R6: assert property (@(posedge clk) disable iff (rst)
            !en[i] |-> !gate[i]);
    end

endmodule

bind led_burst_dimmer led_dim_checker #(.N(N_STR), .CAR_W(CAR_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .en       (str_en_i),
    .gate     (gate_o),
    .level    (car_level),
    .wrap     (car_wrap),
    .duty_all (duty_all)
);

// File: tb/led_burst_dimmer_test.sv
`timescale 1ns/1ps
module led_burst_dimmer_test;
    localparam int NS   = 5;
    localparam int SW   = 10;
    localparam int CW   = 4;
    localparam int PEAK = 1 << CW;
    localparam int PER  = 2 * PEAK;
    localparam int HALF = PEAK / 2;
    localparam int SEG  = 256;
    localparam int NCYC = 7 * SEG;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [SW-1:0]   ref_v = '0;
    logic [7:0]      gain = '0;
    logic [NS-1:0]   en = '0;
    logic [NS*SW-1:0] samp = '0;
    logic [NS-1:0]   gate;

    int    m_phase;
    int    m_duty [NS];
    int    m_acc  [NS];
    int    n_cmp = 0;
    int    n_bad = 0;
    bit    done  = 1'b0;
    string tag   = "R1";

    led_burst_dimmer uut (
        .clk      (clk),
        .rst      (rst),
        .ref_i    (ref_v),
        .gain_i   (gain),
        .str_en_i (en),
        .samp_i   (samp),
        .gate_o   (gate)
    );

    always #2 clk = ~clk;

    function automatic int car(input int ph);
        return (ph < PEAK) ? ph : (PER - 1 - ph);
    endfunction

    function automatic int floor16(input int p);
        return (p >= 0) ? (p / 16) : -((-p + 15) / 16);
    endfunction

    task automatic drive(input int cyc);
        int seg;
        int loc;
        int r;
        seg = cyc / SEG;
        loc = cyc % SEG;
        rst = (seg == 0 && loc < 3) || (seg == 5 && loc < 2);
        en  = '1;
        case (seg)
            0: begin
                ref_v = 10'd60; gain = 8'd8;
                for (int s = 0; s < NS; s++) samp[s*SW +: SW] = SW'(s * 20 + 40);
                tag = (loc < 35) ? "R1" : "R2";
            end
            1: begin
                ref_v = 10'd1023; gain = 8'd255; samp = '0; tag = "R5";
            end
            2: begin
                ref_v = 10'd0; gain = 8'd255; samp = '1; tag = "R5";
            end
            3: begin
                ref_v = 10'd200; gain = 8'd24;
                en = ((loc / 45) % 2 == 1) ? 5'b10101 : 5'b11111;
                for (int s = 0; s < NS; s++) samp[s*SW +: SW] = SW'(150 + s);
                tag = "R6";
            end
            4: begin
                ref_v = 10'd300; gain = 8'd20;
                for (int s = 0; s < NS; s++) samp[s*SW +: SW] = SW'($urandom_range(0, 1023));
                tag = "R3";
            end
            5: begin
                ref_v = 10'd500; gain = 8'd12;
                r = $urandom_range(0, 1023);
                for (int s = 0; s < NS; s++) samp[s*SW +: SW] = SW'(r);
                tag = "R7";
            end
            default: begin
                ref_v = 10'd400; gain = 8'd40;
                for (int s = 0; s < NS; s++) samp[s*SW +: SW] = SW'(s * 100 + 100);
                tag = "R4";
            end
        endcase
    endtask

    task automatic compare_outputs();
        int exp_g;
        for (int s = 0; s < NS; s++) begin
            exp_g = (en[s] && (m_duty[s] > car(m_phase))) ? 1 : 0;
            n_cmp++;
            if (int'(gate[s]) != exp_g) begin
                n_bad++;
                $display("FAIL %s string %0d phase %0d: gate actual %0d expected %0d",
                         tag, s, m_phase, gate[s], exp_g);
            end
        end
        if (tag == "R7") begin
            n_cmp++;
            if (gate != '0 && gate != '1) begin
                n_bad++;
                $display("FAIL R7 balance: gates actual %b expected all equal", gate);
            end
        end
    endtask

    task automatic model_step();
        int g;
        int avg;
        int d;
        if (rst) begin
            m_phase = 0;
            for (int s = 0; s < NS; s++) begin
                m_duty[s] = HALF;
                m_acc[s]  = 0;
            end
        end else begin
            for (int s = 0; s < NS; s++) begin
                g = (en[s] && (m_duty[s] > car(m_phase))) ? 1 : 0;
                if (g == 1) m_acc[s] += int'(samp[s*SW +: SW]);
                if (!en[s]) m_acc[s] = 0;
                if (m_phase == PER - 1) begin
                    if (en[s]) begin
                        avg = m_acc[s] / PER;
                        d = HALF + floor16((int'(ref_v) - avg) * int'(gain));
                        if (d < 0) d = 0;
                        if (d > PEAK) d = PEAK;
                        m_duty[s] = d;
                    end else begin
                        m_duty[s] = HALF;
                    end
                    m_acc[s] = 0;
                end
            end
            m_phase = (m_phase + 1) % PER;
        end
    endtask

    initial begin
        for (int cyc = 0; cyc < NCYC; cyc++) begin
            @(negedge clk);
            drive(cyc);
            #1;
            if (!rst) compare_outputs();
            model_step();
        end
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: run actual hung expected finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule